// File: doc/BRIEF.md
# Line Uniformity Statistics Engine

This block measures how evenly the pixels of one scanned line respond. A stream of digitised samples arrives one per clock, each tagged as a real photocell or as a sample to skip. Skipped samples include shielded reference cells and the dummy cells at either end of the line. Over the tagged samples the engine keeps a running sum, minimum and maximum. After the line ends it derives the mean level, the deviation of the brightest and the darkest pixel from that mean, the larger of the two, and that larger deviation as a whole-number percentage of the mean.

Run with the sensor covered, the mean is the average dark signal and the largest deviation is the dark non-uniformity. Run under uniform light, the percentage is the photo-response non-uniformity. Because only the minimum and maximum are kept, no line buffer and no second pass are needed. The two divisions share one restoring divider that runs after the end-of-line strobe. A done flag rises once every result is valid and stays up until the next start-of-line strobe.

Top module: `line_unif_stats`

## Requirements
- R1: A start-of-line pulse on `sol` starts a new line. From the next cycle, `done`, `zero_err` and `cnt_err` are low. Anything gathered since the previous `sol` is discarded, including any calculation still running.
- R2: Only samples with `smp_vld` high take part. A sample with `smp_vld` low has no effect on any result, whatever its value.
- R3: `mean_lvl` is the sum of the accepted samples divided by the parameter `N_VALID`, rounded down.
- R4: `dev_pos` is the largest accepted sample minus `mean_lvl`, and `dev_neg` is `mean_lvl` minus the smallest accepted sample. Each is forced to 0 when the difference would be negative.
- R5: `dev_max` equals the larger of `dev_pos` and `dev_neg`.
- R6: When `mean_lvl` is not zero, `pct` is `dev_max`×100 divided by `mean_lvl`, rounded down.
- R7: When `mean_lvl` is zero, `pct` is all ones and `zero_err` is high.
- R8: `cnt_err` is high when the line held a number of valid samples other than `N_VALID`, and the results are still reported. Only the first `N_VALID` valid samples of a line are accepted; later ones are left out of the sum, minimum and maximum.
- R9: After an `eol` pulse ends a line, `done` rises once all results are ready. It stays high with all results unchanged until the next `sol`. A valid sample given together with `eol` is the last sample of the line.
- R10: After reset, `done`, both flags and all result outputs are zero.
- R11: An `eol` pulse while no line is being gathered, for example after `done`, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sol | input | 1 | Start-of-line pulse |
| eol | input | 1 | End-of-line pulse |
| smp_vld | input | 1 | Sample belongs to a real photocell |
| smp_dat | input | PIX_W | Unsigned sample value |
| done | output | 1 | Results valid |
| mean_lvl | output | PIX_W | Line mean, rounded down |
| dev_pos | output | PIX_W | Maximum minus mean, floored at 0 |
| dev_neg | output | PIX_W | Mean minus minimum, floored at 0 |
| dev_max | output | PIX_W | Larger deviation |
| pct | output | PIX_W+7 | Deviation as a percentage of the mean |
| zero_err | output | 1 | Mean was zero, percentage saturated |
| cnt_err | output | 1 | Valid-sample count differed from N_VALID |

## Verification
The assertions check on every cycle that results stay frozen while `done` is high, and that `sol` clears the done flag and both error flags. They also check that `dev_max` is one of the two deviations and not below either, that `pct` lies within one mean-sized step of `dev_max`×100, and that a zero mean always comes with a saturated percentage. The mean itself and the exclusion of untagged or surplus samples depend on the pixel data, which the outputs do not expose. Only the bench scenarios can show these: lines with interleaved invalid samples, short lines, over-long lines, an all-zero line, and a line restarted halfway.

// File: rtl/lus_pkg.sv
package lus_pkg;

    // Sequencer states of the statistics engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_MEAN_GO,
        ST_MEAN_WAIT,
        ST_DEV,
        ST_PCT_GO,
        ST_PCT_WAIT,
        ST_DONE
    } lus_state_e;

    // Error flags reported with the results
    typedef struct packed {
        logic zero_mean;
        logic count_bad;
    } lus_flags_t;

    localparam int unsigned PCT_SCALE = 100;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned scale_bits(input int unsigned s);
        return $clog2(s + 1);
    endfunction

endpackage

// File: rtl/lus_accum.sv
module lus_accum #(
    parameter int PIX_W   = 12,
    parameter int N_VALID = 5300,
    parameter int CNT_W   = $clog2(N_VALID + 1),
    parameter int SUM_W   = PIX_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             vld,
    input  logic [PIX_W-1:0] smp,
    output logic [SUM_W-1:0] sum_o,
    output logic [PIX_W-1:0] min_o,
    output logic [PIX_W-1:0] max_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             extra_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(N_VALID);

    logic [SUM_W-1:0] sum_q, b_sum, n_sum;
    logic [PIX_W-1:0] min_q, b_min, n_min;
    logic [PIX_W-1:0] max_q, b_max, n_max;
    logic [CNT_W-1:0] cnt_q, b_cnt, n_cnt;
    logic             ext_q, b_ext, n_ext;

    always_comb begin
        // a start pulse restarts from the empty state in the same cycle
        b_sum = clr ? '0 : sum_q;
        b_min = clr ? '1 : min_q;
        b_max = clr ? '0 : max_q;
        b_cnt = clr ? '0 : cnt_q;
        b_ext = clr ? 1'b0 : ext_q;
        n_sum = b_sum;
        n_min = b_min;
        n_max = b_max;
        n_cnt = b_cnt;
        n_ext = b_ext;
        if (vld && (en || clr)) begin
            if (b_cnt < LIMIT) begin
                n_sum = b_sum + SUM_W'(smp);
                n_cnt = b_cnt + 1'b1;
                if (smp < b_min) n_min = smp;
                if (smp > b_max) n_max = smp;
            end else begin
                n_ext = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            min_q <= '1;
            max_q <= '0;
            cnt_q <= '0;
            ext_q <= 1'b0;
        end else begin
            sum_q <= n_sum;
            min_q <= n_min;
            max_q <= n_max;
            cnt_q <= n_cnt;
            ext_q <= n_ext;
        end
    end

    assign sum_o   = sum_q;
    assign min_o   = min_q;
    assign max_o   = max_q;
    assign cnt_o   = cnt_q;
    assign extra_o = ext_q;

endmodule

// File: rtl/lus_div.sv
module lus_div #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quot
);

    localparam int SW = $clog2(W + 1);
    localparam logic [SW-1:0] LAST = SW'(W - 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [SW-1:0] step_q;
    logic          busy_q, fin_q;
    logic [W:0]    trial;
    logic          fits;

    // one quotient bit per cycle, most significant first
    assign trial = {rem_q, quo_q[W-1]};
    assign fits  = (trial >= {1'b0, dvs_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
            step_q <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
            quo_q  <= {quo_q[W-2:0], fits};
            step_q <= step_q + 1'b1;
            if (step_q == LAST) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign quot = quo_q;

endmodule

// File: rtl/line_unif_stats.sv
module line_unif_stats
    import lus_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int N_VALID = 5300
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sol,
    input  logic                   eol,
    input  logic                   smp_vld,
    input  logic [PIX_W-1:0]       smp_dat,
    output logic                   done,
    output logic [PIX_W-1:0]       mean_lvl,
    output logic [PIX_W-1:0]       dev_pos,
    output logic [PIX_W-1:0]       dev_neg,
    output logic [PIX_W-1:0]       dev_max,
    output logic [PIX_W+6:0]       pct,
    output logic                   zero_err,
    output logic                   cnt_err
);

    localparam int CNT_W = $clog2(N_VALID + 1);
    localparam int SUM_W = PIX_W + CNT_W;
    localparam int SCL_W = scale_bits(PCT_SCALE);
    localparam int PCT_W = PIX_W + SCL_W;
    localparam int DIV_W = max_u(SUM_W, PCT_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_VALID);

    lus_state_e       state_q;
    lus_flags_t       flags_q;
    logic [SUM_W-1:0] acc_sum;
    logic [PIX_W-1:0] acc_min, acc_max;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_extra;
    logic             acc_en;
    logic             div_start, div_busy, div_fin;
    logic [DIV_W-1:0] div_num, div_den, div_quo;
    logic [PIX_W-1:0] mean_q, dpos_q, dneg_q, dmax_q;
    logic [PIX_W-1:0] dpos_w, dneg_w;
    logic [PCT_W-1:0] pct_q;
    logic             done_q;

    assign acc_en = (state_q == ST_COLLECT);

    lus_accum #(
        .PIX_W   (PIX_W),
        .N_VALID (N_VALID),
        .CNT_W   (CNT_W),
        .SUM_W   (SUM_W)
    ) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (sol),
        .en      (acc_en),
        .vld     (smp_vld),
        .smp     (smp_dat),
        .sum_o   (acc_sum),
        .min_o   (acc_min),
        .max_o   (acc_max),
        .cnt_o   (acc_cnt),
        .extra_o (acc_extra)
    );

    // the shared divider first forms the mean, then the percentage
    always_comb begin
        if (state_q == ST_MEAN_GO) begin
            div_num = DIV_W'(acc_sum);
            div_den = DIV_W'(N_VALID);
        end else begin
            div_num = DIV_W'(dmax_q) * DIV_W'(PCT_SCALE);
            div_den = DIV_W'(mean_q);
        end
    end

    assign div_start = !sol && ((state_q == ST_MEAN_GO) ||
                                ((state_q == ST_PCT_GO) && (mean_q != '0)));

    lus_div #(
        .W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .busy     (div_busy),
        .fin      (div_fin),
        .quot     (div_quo)
    );

    // deviations floored at zero when the mean lies outside [min, max]
    assign dpos_w = (acc_max > mean_q) ? (acc_max - mean_q) : '0;
    assign dneg_w = (mean_q > acc_min) ? (mean_q - acc_min) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            mean_q  <= '0;
            dpos_q  <= '0;
            dneg_q  <= '0;
            dmax_q  <= '0;
            pct_q   <= '0;
            done_q  <= 1'b0;
        end else if (sol) begin
            state_q <= ST_COLLECT;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_COLLECT: begin
                    if (eol) state_q <= ST_MEAN_GO;
                end
                ST_MEAN_GO: begin
                    flags_q.count_bad <= (acc_cnt != FULL_CNT) || acc_extra;
                    state_q <= ST_MEAN_WAIT;
                end
                ST_MEAN_WAIT: begin
                    if (div_fin) begin
                        mean_q  <= div_quo[PIX_W-1:0];
                        state_q <= ST_DEV;
                    end
                end
                ST_DEV: begin
                    dpos_q  <= dpos_w;
                    dneg_q  <= dneg_w;
                    dmax_q  <= (dpos_w > dneg_w) ? dpos_w : dneg_w;
                    state_q <= ST_PCT_GO;
                end
                ST_PCT_GO: begin
                    if (mean_q == '0) begin
                        pct_q             <= '1;
                        flags_q.zero_mean <= 1'b1;
                        done_q            <= 1'b1;
                        state_q           <= ST_DONE;
                    end else begin
                        state_q <= ST_PCT_WAIT;
                    end
                end
                ST_PCT_WAIT: begin
                    if (div_fin) begin
                        pct_q   <= div_quo[PCT_W-1:0];
                        done_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign done     = done_q;
    assign mean_lvl = mean_q;
    assign dev_pos  = dpos_q;
    assign dev_neg  = dneg_q;
    assign dev_max  = dmax_q;
    assign pct      = pct_q;
    assign zero_err = flags_q.zero_mean;
    assign cnt_err  = flags_q.count_bad;

endmodule

// File: rtl/lus_chk.sv
module lus_chk #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             sol,
    input logic             done,
    input logic [PIX_W-1:0] mean_lvl,
    input logic [PIX_W-1:0] dev_pos,
    input logic [PIX_W-1:0] dev_neg,
    input logic [PIX_W-1:0] dev_max,
    input logic [PIX_W+6:0] pct,
    input logic             zero_err,
    input logic             cnt_err
);

    logic [63:0] num_w, lo_w, hi_w;

    assign num_w = 64'(dev_max) * 64'd100;
    assign lo_w  = 64'(pct) * 64'(mean_lvl);
    assign hi_w  = lo_w + 64'(mean_lvl);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !sol) |=> done);

    // R9
    result_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !sol) |=> ($stable(mean_lvl) && $stable(pct) && $stable(dev_max) &&
                            $stable(dev_pos) && $stable(dev_neg) && $stable(cnt_err)));

    // R1
    sol_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sol |=> (!done && !zero_err && !cnt_err));

    // R5
    dev_pick_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((dev_max >= dev_pos) && (dev_max >= dev_neg) &&
                  ((dev_max == dev_pos) || (dev_max == dev_neg))));

    // R6
    pct_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !zero_err) |-> ((num_w >= lo_w) && (num_w < hi_w)));

    // R7
    zero_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (done && zero_err) |-> ((pct == '1) && (mean_lvl == '0)));

endmodule

bind line_unif_stats lus_chk #(.PIX_W(PIX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sol      (sol),
    .done     (done),
    .mean_lvl (mean_lvl),
    .dev_pos  (dev_pos),
    .dev_neg  (dev_neg),
    .dev_max  (dev_max),
    .pct      (pct),
    .zero_err (zero_err),
    .cnt_err  (cnt_err)
);

// File: tb/line_unif_stats_bench.sv
module line_unif_stats_bench;

    localparam int PW    = 12;
    localparam int NV    = 8;
    localparam int PCTW  = PW + 7;
    localparam int SLOTS = 10;
    localparam int NVEC  = 6;

    // stimulus: ten slots per line, mask bit j marks slot j valid
    localparam logic [SLOTS-1:0][PW-1:0] VSMP [NVEC] = '{
        {12'd4095, 12'd4095, 12'd100, 12'd100, 12'd100, 12'd100, 12'd100, 12'd100, 12'd100, 12'd100},
        {12'd4000, 12'd4000, 12'd80, 12'd70, 12'd60, 12'd50, 12'd40, 12'd30, 12'd20, 12'd10},
        {12'd5, 12'd900, 12'd7, 12'd1000, 12'd3, 12'd1200, 12'd9, 12'd800, 12'd11, 12'd600},
        {12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0},
        {12'd1, 12'd1, 12'd1, 12'd200, 12'd300, 12'd400, 12'd500, 12'd600, 12'd700, 12'd4095},
        {12'd9, 12'd9, 12'd2000, 12'd2100, 12'd1900, 12'd2050, 12'd1950, 12'd2000, 12'd2010, 12'd1990}
    };
    localparam logic [SLOTS-1:0] VMSK [NVEC] = '{
        10'b0011111111, 10'b0011111111, 10'b1111011110,
        10'b0011111111, 10'b0001111111, 10'b1111111111
    };
    // expected flags per vector
    localparam logic VCE [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic VZE [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sol = 1'b0;
    logic            eol = 1'b0;
    logic            smp_vld = 1'b0;
    logic [PW-1:0]   smp_dat = '0;
    logic            done;
    logic [PW-1:0]   mean_lvl, dev_pos, dev_neg, dev_max;
    logic [PCTW-1:0] pct;
    logic            zero_err, cnt_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int e_mean, e_dp, e_dn, e_dm, e_pct;
    bit e_ce, e_ze;

    always #2 clk = ~clk;

    line_unif_stats #(.PIX_W(PW), .N_VALID(NV)) u_line_unif_stats (
        .clk      (clk),
        .rst      (rst),
        .sol      (sol),
        .eol      (eol),
        .smp_vld  (smp_vld),
        .smp_dat  (smp_dat),
        .done     (done),
        .mean_lvl (mean_lvl),
        .dev_pos  (dev_pos),
        .dev_neg  (dev_neg),
        .dev_max  (dev_max),
        .pct      (pct),
        .zero_err (zero_err),
        .cnt_err  (cnt_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference from the requirements
    task automatic model(input int v);
        int sum = 0, cnt = 0, acc = 0, mn = 4095, mx = 0;
        for (int j = 0; j < SLOTS; j++) begin
            if (VMSK[v][j]) begin
                cnt++;
                if (acc < NV) begin
                    acc++;
                    sum += int'(VSMP[v][j]);
                    if (int'(VSMP[v][j]) < mn) mn = int'(VSMP[v][j]);
                    if (int'(VSMP[v][j]) > mx) mx = int'(VSMP[v][j]);
                end
            end
        end
        e_mean = sum / NV;
        e_dp   = (mx > e_mean) ? mx - e_mean : 0;
        e_dn   = (e_mean > mn) ? e_mean - mn : 0;
        e_dm   = (e_dp > e_dn) ? e_dp : e_dn;
        e_ze   = (e_mean == 0);
        e_pct  = e_ze ? (1 << PCTW) - 1 : (e_dm * 100) / e_mean;
        e_ce   = (cnt != NV);
    endtask

    task automatic start_line();
        @(negedge clk);
        sol = 1'b1;
        @(negedge clk);
        sol = 1'b0;
    endtask

    task automatic feed(input int v);
        for (int j = 0; j < SLOTS; j++) begin
            smp_vld = VMSK[v][j];
            smp_dat = VSMP[v][j];
            eol     = (j == SLOTS - 1);
            @(negedge clk);
        end
        smp_vld = 1'b0;
        smp_dat = '0;
        eol     = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_vec(input int v);
        model(v);
        chk((v == 2) ? "R2" : "R3", "mean_lvl", mean_lvl, e_mean);
        chk("R4", "dev_pos", dev_pos, e_dp);
        chk("R4", "dev_neg", dev_neg, e_dn);
        chk("R5", "dev_max", dev_max, e_dm);
        chk(e_ze ? "R7" : "R6", "pct", pct, e_pct);
        chk("R7", "zero_err", zero_err, e_ze);
        chk("R8", "cnt_err", cnt_err, e_ce);
        chk("R8", "cnt_err table", cnt_err, VCE[v]);
        chk("R7", "zero_err table", zero_err, VZE[v]);
    endtask

    initial begin
        bit ok;
        logic [PW-1:0] keep_mean;
        logic [PCTW-1:0] keep_pct;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "done", done, 0);
        chk("R10", "zero_err", zero_err, 0);
        chk("R10", "cnt_err", cnt_err, 0);
        chk("R10", "mean_lvl", mean_lvl, 0);
        chk("R10", "pct", pct, 0);

        for (int v = 0; v < NVEC; v++) begin
            start_line();
            feed(v);
            wait_done(ok);
            chk("R9", "done rose", ok, 1);
            check_vec(v);
        end

        // R11 stray end-of-line after done, R9 results held
        keep_mean = mean_lvl;
        keep_pct  = pct;
        @(negedge clk);
        eol = 1'b1;
        @(negedge clk);
        eol = 1'b0;
        repeat (60) @(negedge clk);
        chk("R11", "done after stray eol", done, 1);
        chk("R11", "mean after stray eol", mean_lvl, keep_mean);
        chk("R9", "pct held", pct, keep_pct);

        // R1 start clears done and flags on the next cycle
        sol = 1'b1;
        @(negedge clk);
        sol = 1'b0;
        chk("R1", "done after sol", done, 0);
        chk("R1", "cnt_err after sol", cnt_err, 0);

        // R1 restart mid-line: partial data must be dropped
        for (int j = 0; j < 5; j++) begin
            smp_vld = 1'b1;
            smp_dat = 12'd4000;
            @(negedge clk);
        end
        smp_vld = 1'b0;
        start_line();
        feed(1);
        wait_done(ok);
        chk("R1", "done after restart", ok, 1);
        model(1);
        chk("R1", "mean after restart", mean_lvl, e_mean);
        chk("R1", "pct after restart", pct, e_pct);

        // R1 start pulse during a running calculation aborts it
        start_line();
        feed(2);
        repeat (4) @(negedge clk);
        start_line();
        repeat (60) @(negedge clk);
        chk("R1", "no done after abort", done, 0);
        feed(0);
        wait_done(ok);
        chk("R1", "done after abort", ok, 1);
        check_vec(0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule